// File: doc/BRIEF.md
# Serial Dual-Wiper Control Register

This block holds the digital settings of a dual digital potentiometer. Software-free control arrives on a three-wire serial port: an enable line, a serial clock and a data line. While the enable is high, each qualified rising serial-clock edge moves one data bit into a 17-bit shift register. When the enable drops, the whole shift register is copied into the two 8-bit wiper codes and the one-bit stack select. The serial lines are sampled by the system clock through a short synchronizer, so the serial clock must stay in each phase for more than `SYNC_STAGES` system clocks.

The bit that leaves the far end of the shift register is presented on a cascade output. Several devices can therefore be chained, with 17 bits per device. If the last cascade output is looped back to the first data input, clocking one full rotation reads every setting out and puts it back unchanged. A 9-bit stacked tap index combines the stack select with the selected wiper code, for a 512-tap series arrangement of the two ladders.

Top module: `potSerialTop`

## Requirements
- R1: After reset, both wiper codes are 0x80, the stack select is 0, the cascade output is 0 and the tap index is 0x080.
- R2: A frame is 17 bits. The first bit shifted in becomes the stack select. The next 8 bits, MSB first, become wiper 1. The last 8 bits, MSB first, become wiper 0. The values are applied when the enable falls.
- R3: While the enable is high, the wiper codes, stack select and tap index keep their previous values, however many bits are clocked.
- R4: Serial-clock edges while the enable is low are ignored: neither the shift register nor the outputs change. An enable pulse with no clock edges reapplies the current settings unchanged.
- R5: After N < 17 clocked bits, the applied 17-bit value is the earlier shift contents moved up by N positions, with the N new bits in the low positions.
- R6: After more than 17 clocked bits, only the last 17 bits are applied.
- R7: The cascade output always shows the top (17th) bit of the shift register. After each shift it shows the next bit that will leave, so the old frame comes out in the order stack select, wiper 1 MSB to LSB, wiper 0 MSB to LSB.
- R8: The tap index is {stack select, wiper 0} when the stack select is 0, and {stack select, wiper 1} when it is 1.
- R9: From reset, and after any write, 17 clocks per device in a looped chain leave every setting unchanged. This holds because the shift register starts out equal to the reset settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serEn | input | 1 | Serial enable; high admits shifting, falling edge applies the frame |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data in |
| casOut | output | 1 | Cascade output, top bit of the shift register |
| wiper0 | output | 8 | Wiper 0 code (lower ladder) |
| wiper1 | output | 8 | Wiper 1 code (upper ladder) |
| stackSel | output | 1 | Stack select |
| tapIdx | output | 9 | Stacked tap index |

## Verification
Four properties are checked on every cycle: the reset values when reset is released, the wiper codes and stack select holding except on an apply strobe, the cascade output changing only on a shift strobe, and the stack select matching the cascade bit right after an apply. Frame ordering, partial and over-long frames, the ignoring of idle clocks, the tap multiplexing and the non-destructive read of a looped two-device chain depend on whole serial sequences. Only the bench scenarios can show these, by comparing the outputs against a chain model after each frame.

// File: rtl/potPkg.sv
package potPkg;
  // strobes from the serial control to the datapath
  typedef struct packed {
    logic shift;  // one qualified rising serial-clock edge
    logic load;   // enable has fallen: apply the frame
    logic bitIn;  // synchronized data bit for the shift
  } potStrobe_t;
endpackage

// File: rtl/potCtrl.sv
module potCtrl
  import potPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEn,
  input  logic       serClk,
  input  logic       serData,
  output potStrobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] enPipe;
  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] datPipe;
  logic enPrev;
  logic clkPrev;

  // all three lines share one pipeline depth so a chained neighbour's
  // cascade bit lines up with the clock edge that consumes it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPipe  <= '0;
      clkPipe <= '0;
      datPipe <= '0;
      enPrev  <= 1'b0;
      clkPrev <= 1'b0;
    end else begin
      enPipe[0]  <= serEn;
      clkPipe[0] <= serClk;
      datPipe[0] <= serData;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        enPipe[i]  <= enPipe[i-1];
        clkPipe[i] <= clkPipe[i-1];
        datPipe[i] <= datPipe[i-1];
      end
      enPrev  <= enPipe[LAST];
      clkPrev <= clkPipe[LAST];
    end
  end

  always_comb begin
    strb.shift = enPipe[LAST] & clkPipe[LAST] & ~clkPrev;
    strb.load  = ~enPipe[LAST] & enPrev;
    strb.bitIn = datPipe[LAST];
  end
endmodule

// File: rtl/potData.sv
module potData
  import potPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  potStrobe_t        strb,
  output logic              casOut,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1,
  output logic              stackSel,
  output logic [CODE_W:0]   tapIdx
);
  localparam int FRAME_W = 2 * CODE_W + 1;
  localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [FRAME_W-1:0] INIT_FRAME = {1'b0, HALF, HALF};

  logic [FRAME_W-1:0] shiftReg;

  // shift register starts equal to the live settings so a rotation is neutral
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= INIT_FRAME;
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], strb.bitIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackSel <= 1'b0;
      wiper1   <= HALF;
      wiper0   <= HALF;
    end else if (strb.load) begin
      stackSel <= shiftReg[FRAME_W-1];
      wiper1   <= shiftReg[FRAME_W-2:CODE_W];
      wiper0   <= shiftReg[CODE_W-1:0];
    end
  end

  assign casOut = shiftReg[FRAME_W-1];

  always_comb begin
    tapIdx = {stackSel, (stackSel ? wiper1 : wiper0)};
  end
endmodule

// File: rtl/potSerialTop.sv
module potSerialTop
  import potPkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serEn,
  input  logic              serClk,
  input  logic              serData,
  output logic              casOut,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1,
  output logic              stackSel,
  output logic [CODE_W:0]   tapIdx
);
  potStrobe_t strb;

  potCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk),
    .serData(serData), .strb(strb)
  );

  potData #(.CODE_W(CODE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .casOut(casOut),
    .wiper0(wiper0), .wiper1(wiper1), .stackSel(stackSel), .tapIdx(tapIdx)
  );
endmodule

// File: rtl/potSerialChk.sv
module potSerialChk
  import potPkg::*;
#(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input potStrobe_t        strb,
  input logic              casOut,
  input logic [CODE_W-1:0] wiper0,
  input logic [CODE_W-1:0] wiper1,
  input logic              stackSel
);
  localparam logic [CODE_W-1:0] HALF = {1'b1, {(CODE_W-1){1'b0}}};

  a_r1_reset_vals: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (wiper0 == HALF && wiper1 == HALF && !stackSel && !casOut));

  a_r3_hold_no_load: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(wiper0) && $stable(wiper1) && $stable(stackSel)));

  a_r4_cas_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(casOut));

  a_r2_load_top_bit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.shift) |=> (stackSel == casOut));
endmodule

bind potSerialTop potSerialChk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .casOut(casOut),
  .wiper0(wiper0), .wiper1(wiper1), .stackSel(stackSel)
);

// File: tb/potSerialTop_bench.sv
module potSerialTop_bench;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0;
  logic serClk = 1'b0;
  logic drvData = 1'b0;
  logic loopMode = 1'b0;
  logic din1;
  logic cas1, cas2, ss1, ss2;
  logic [7:0] w0a, w1a, w0b, w1b;
  logic [8:0] tapA, tapB;

  int nChecks = 0;
  int nErr = 0;
  logic [16:0] m1, m2, a1, a2;

  always #10 clk = ~clk;

  assign din1 = loopMode ? cas2 : drvData;

  potSerialTop u_potSerialTop (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serData(din1),
    .casOut(cas1), .wiper0(w0a), .wiper1(w1a), .stackSel(ss1), .tapIdx(tapA)
  );
  potSerialTop u_potSecond (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serData(cas1),
    .casOut(cas2), .wiper0(w0b), .wiper1(w1b), .stackSel(ss2), .tapIdx(tapB)
  );

  function automatic logic [8:0] expTap(input logic [16:0] f);
    return {f[16], (f[16] ? f[15:8] : f[7:0])};
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkApplied(input string req);
    chk({1'b0, w0a}, {1'b0, a1[7:0]}, {req, " dev1 wiper0"});
    chk({1'b0, w1a}, {1'b0, a1[15:8]}, {req, " dev1 wiper1"});
    chk({8'd0, ss1}, {8'd0, a1[16]}, {req, " dev1 stack"});
    chk(tapA, expTap(a1), {req, " R8 dev1 tap"});
    chk({8'd0, cas1}, {8'd0, m1[16]}, {req, " R7 dev1 cascade"});
    chk({1'b0, w0b}, {1'b0, a2[7:0]}, {req, " dev2 wiper0"});
    chk({1'b0, w1b}, {1'b0, a2[15:8]}, {req, " dev2 wiper1"});
    chk({8'd0, ss2}, {8'd0, a2[16]}, {req, " dev2 stack"});
    chk(tapB, expTap(a2), {req, " R8 dev2 tap"});
    chk({8'd0, cas2}, {8'd0, m2[16]}, {req, " R7 dev2 cascade"});
  endtask

  // one serial bit; model shifts on the rising serial edge when enabled
  task automatic clockBit(input logic b, input bit chkCas);
    logic in1, out1;
    drvData = b;
    waitN(HOLD);
    serClk = 1'b1;
    if (serEn) begin
      in1  = loopMode ? m2[16] : b;
      out1 = m1[16];
      m1 = {m1[15:0], in1};
      m2 = {m2[15:0], out1};
    end
    waitN(HOLD);
    if (chkCas) begin
      chk({8'd0, cas1}, {8'd0, m1[16]}, "R7 dev1 shifting cascade");
      chk({8'd0, cas2}, {8'd0, m2[16]}, "R7 dev2 shifting cascade");
    end
    serClk = 1'b0;
  endtask

  task automatic startFrame();
    serEn = 1'b1;
    waitN(HOLD);
  endtask

  task automatic endFrame();
    waitN(HOLD);
    serEn = 1'b0;
    a1 = m1;
    a2 = m2;
    waitN(HOLD + 3);
  endtask

  task automatic sendWord(input logic [16:0] f, input bit chkCas);
    for (int i = 16; i >= 0; i--) clockBit(f[i], chkCas);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    nChecks++;
    $display("FAIL watchdog timeout");
    finishRun();
  end

  initial begin
    logic [16:0] save1, save2;
    int unsigned r;
    r = $urandom(32'd2417);
    m1 = {1'b0, 8'h80, 8'h80};
    m2 = m1;
    a1 = m1;
    a2 = m1;
    waitN(3);
    rstN = 1'b1;
    waitN(3);
    checkApplied("R1 reset");

    // R9: looped rotation straight from reset
    loopMode = 1'b1;
    startFrame();
    for (int i = 0; i < 34; i++) clockBit(1'b0, 1'b1);
    endFrame();
    chk({1'b0, w0a}, 9'h080, "R9 reset rotation wiper0");
    chk({8'd0, ss2}, 9'h000, "R9 reset rotation stack");
    checkApplied("R9 reset rotation");
    loopMode = 1'b0;

    // R2 directed: dev2 frame first, then dev1 frame; R3 mid-frame
    startFrame();
    sendWord({1'b0, 8'h3C, 8'hA5}, 1'b1);
    for (int i = 16; i > 8; i--) clockBit(logic'((17'h1_5A_C3 >> i) & 1), 1'b1);
    checkApplied("R3 mid-frame hold");
    for (int i = 8; i >= 0; i--) clockBit(logic'((17'h1_5A_C3 >> i) & 1), 1'b1);
    endFrame();
    chk({1'b0, w1a}, 9'h05A, "R2 dev1 wiper1 code");
    chk({1'b0, w0b}, 9'h0A5, "R2 dev2 wiper0 code");
    chk(tapA, 9'h15A, "R8 stack=1 picks wiper1");
    chk(tapB, 9'h0A5, "R8 stack=0 picks wiper0");
    checkApplied("R2 directed");

    // R4: clocks with enable low are ignored, empty pulse reapplies
    for (int i = 0; i < 6; i++) clockBit(logic'(i & 1), 1'b0);
    waitN(HOLD);
    checkApplied("R4 idle clocks");
    startFrame();
    endFrame();
    checkApplied("R4 empty enable pulse");

    // R5 partial frame
    startFrame();
    for (int i = 0; i < 5; i++) clockBit(logic'(i & 1), 1'b1);
    endFrame();
    checkApplied("R5 partial frame");

    // R6 over-long frame
    startFrame();
    for (int i = 0; i < 40; i++) clockBit(logic'((i * 7 + 3) % 5 == 0), 1'b1);
    endFrame();
    checkApplied("R6 long frame");

    // R9: looped two-device read back leaves settings intact
    save1 = a1;
    save2 = a2;
    loopMode = 1'b1;
    startFrame();
    for (int i = 0; i < 34; i++) clockBit(1'b0, 1'b1);
    endFrame();
    loopMode = 1'b0;
    chk({w1a[7:0], ss1}, {save1[15:8], save1[16]}, "R9 loop dev1 unchanged");
    chk({1'b0, w0b}, {1'b0, save2[7:0]}, "R9 loop dev2 unchanged");
    checkApplied("R9 loop readback");

    // random frames of random length and mode
    for (int f = 0; f < 40; f++) begin
      int len;
      len = 1 + int'($urandom % 40);
      loopMode = ($urandom % 4) == 0;
      startFrame();
      for (int i = 0; i < len; i++) clockBit(logic'($urandom % 2), 1'b1);
      endFrame();
      loopMode = 1'b0;
      if (len < 17) checkApplied("R5 random partial");
      else if (len > 17) checkApplied("R6 random long");
      else checkApplied("R2 random full");
    end
    finishRun();
  end
endmodule